// File: doc/BRIEF.md
# Temperature Threshold Alert Controller

This block sits beside one on-chip temperature sensing channel. It keeps the most recent 12-bit sensor code and compares every accepted sample against three programmable limit codes. For each limit it records two sticky events: the sample reached or passed the limit, or the sample fell below it. The six event flags are qualified by an enable register and a mask register, and the result drives one registered interrupt line.

Software reaches the block through a plain 32-bit register bus. Writes are strobed, and reads are combinational from the address. The run control register has a power-down request bit and a start bit. After reset the power-down request is set. Firmware clears it, programs the limits, enables and mask, and then sets the start bit. Samples are taken only in that running state.

Top module: `thermal_alert_ctrl`

## Requirements
- R1: After reset, the event register (0x04), the enable (0x10), the mask (0x08), the interrupt configuration (0x0C), the three limits and the current code (0x28) all read zero. The run control register (0x20) reads 0x40 and `irq_o` is low.
- R2: The mask (0x08), interrupt configuration (0x0C) and enable (0x10) registers store bits 5:0. The limit registers at 0x14, 0x18 and 0x1C store bits 11:0. The run control register (0x20) stores bit 6 (power-down request) and bit 0 (start). All other bits read as zero.
- R3: A sample with `sample_vld_i` high is accepted only while control bit 6 is 0 and bit 0 is 1. When a sample is not accepted, neither the code register (0x28, bits 11:0) nor the event flags change.
- R4: An accepted sample sets event bit k (k = 0, 1, 2) when the sample code is greater than or equal to limit k+1. Limit k+1 is at 0x14 + 4k.
- R5: An accepted sample sets event bit 3+k when the sample code is less than limit k+1.
- R6: Event flags stay set until software clears them. A write to 0x04 clears each flag whose written bit is 0, so writing zero clears all flags. A flag set by a sample in the same cycle as such a write stays set.
- R7: `irq_o` is the OR over the six bits of (events AND enable AND mask). It is registered, so it follows that term one clock later. A flag whose enable bit or mask bit is 0 never raises it.
- R8: Writes to offsets outside the register map, and writes to the code register at 0x28, change no state. Reads from unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| sample_vld_i | input | 1 | Sample code strobe |
| sample_code_i | input | 12 | Sensor code |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a status write that clears flags in the same clock edge as an accepted sample that sets them. It only happens when the bus strobe and the sample strobe are driven in one cycle. A dedicated task raises both together and then reads back that the newly set bits survived.

Sample codes equal to a limit are a second corner. They are placed exactly on a limit value so that the greater-or-equal and less-than events split there. Every interrupt gating case is applied with flags already pending, so the change on `irq_o` can only come from the enable and mask registers.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int CODE_W  = 12;
  localparam int NUM_LIM = 3;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int FLAG_W  = 2 * NUM_LIM;

  localparam logic [ADDR_W-1:0] ADR_EVT   = 8'h04;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 8'h08;
  localparam logic [ADDR_W-1:0] ADR_ICFG  = 8'h0C;
  localparam logic [ADDR_W-1:0] ADR_ENA   = 8'h10;
  localparam logic [ADDR_W-1:0] ADR_LIM0  = 8'h14;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 8'h20;
  localparam logic [ADDR_W-1:0] ADR_CODE  = 8'h28;

  localparam int CTRL_PD_BIT  = 6;
  localparam int CTRL_RUN_BIT = 0;
endpackage

// File: rtl/thr_compare.sv
module thr_compare
  import thr_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int NL = NUM_LIM
) (
  input  logic [CW-1:0]         code_i,
  input  logic [NL-1:0][CW-1:0] lim_i,
  output logic [NL-1:0]         above_o,
  output logic [NL-1:0]         below_o
);
  for (genvar k = 0; k < NL; k++) begin : g_lim
    assign above_o[k] = (code_i >= lim_i[k]);
    assign below_o[k] = (code_i <  lim_i[k]);
  end
endmodule

// File: rtl/thr_regfile.sv
module thr_regfile
  import thr_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int NL = NUM_LIM,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  input  logic [2*NL-1:0]       evt_i,
  input  logic [CW-1:0]         code_i,
  output logic [NL-1:0][CW-1:0] lim_o,
  output logic [2*NL-1:0]       ena_o,
  output logic [2*NL-1:0]       mask_o,
  output logic                  pd_o,
  output logic                  run_o,
  output logic                  evt_wr_o,
  output logic [2*NL-1:0]       evt_wdata_o
);
  localparam int FW = 2 * NL;

  logic [FW-1:0]         mask_q, ena_q, icfg_q;
  logic [NL-1:0][CW-1:0] lim_q;
  logic                  pd_q, run_q;

  logic                  wr_mask, wr_ena, wr_icfg, wr_ctrl;
  logic [NL-1:0]         wr_lim;
  logic                  addr_hit;

  always_comb begin
    wr_mask = wr_i && (addr_i == ADR_MASK);
    wr_ena  = wr_i && (addr_i == ADR_ENA);
    wr_icfg = wr_i && (addr_i == ADR_ICFG);
    wr_ctrl = wr_i && (addr_i == ADR_CTRL);
    for (int k = 0; k < NL; k++)
      wr_lim[k] = wr_i && (addr_i == AW'(ADR_LIM0 + 4 * k));
    addr_hit = (addr_i == ADR_MASK) || (addr_i == ADR_ENA) ||
               (addr_i == ADR_ICFG) || (addr_i == ADR_CTRL) ||
               (addr_i == ADR_EVT);
    for (int k = 0; k < NL; k++)
      if (addr_i == AW'(ADR_LIM0 + 4 * k)) addr_hit = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ena_q  <= '0;
      icfg_q <= '0;
      pd_q   <= 1'b1;
      run_q  <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= wdata_i[FW-1:0];
      if (wr_ena)  ena_q  <= wdata_i[FW-1:0];
      if (wr_icfg) icfg_q <= wdata_i[FW-1:0];
      if (wr_ctrl) begin
        pd_q  <= wdata_i[CTRL_PD_BIT];
        run_q <= wdata_i[CTRL_RUN_BIT];
      end
    end
  end

  for (genvar k = 0; k < NL; k++) begin : g_lim
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lim_q[k] <= '0;
      else if (wr_lim[k]) lim_q[k] <= wdata_i[CW-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_EVT:  rdata_o[FW-1:0] = evt_i;
      ADR_MASK: rdata_o[FW-1:0] = mask_q;
      ADR_ICFG: rdata_o[FW-1:0] = icfg_q;
      ADR_ENA:  rdata_o[FW-1:0] = ena_q;
      ADR_CTRL: begin
        rdata_o[CTRL_PD_BIT]  = pd_q;
        rdata_o[CTRL_RUN_BIT] = run_q;
      end
      ADR_CODE: rdata_o[CW-1:0] = code_i;
      default:  rdata_o = '0;
    endcase
    for (int k = 0; k < NL; k++)
      if (addr_i == AW'(ADR_LIM0 + 4 * k)) rdata_o[CW-1:0] = lim_q[k];
  end

  assign lim_o       = lim_q;
  assign ena_o       = ena_q;
  assign mask_o      = mask_q;
  assign pd_o        = pd_q;
  assign run_o       = run_q;
  assign evt_wr_o    = wr_i && (addr_i == ADR_EVT);
  assign evt_wdata_o = wdata_i[FW-1:0];

  // R8: writes that hit no register leave the configuration untouched
  a_r8_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !addr_hit) |=> ($stable(mask_q) && $stable(ena_q) && $stable(icfg_q) &&
                             $stable(lim_q) && $stable(pd_q) && $stable(run_q)));

  // R2: control bits change only through a write to the control offset
  a_r2_ctrl_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && addr_i == ADR_CTRL) |=> ($stable(pd_q) && $stable(run_q)));
endmodule

// File: rtl/thr_event.sv
module thr_event
  import thr_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int NL = NUM_LIM
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pd_i,
  input  logic            run_i,
  input  logic            vld_i,
  input  logic [CW-1:0]   code_i,
  input  logic [NL-1:0]   above_i,
  input  logic [NL-1:0]   below_i,
  input  logic            evt_wr_i,
  input  logic [2*NL-1:0] evt_wdata_i,
  input  logic [2*NL-1:0] ena_i,
  input  logic [2*NL-1:0] mask_i,
  output logic [CW-1:0]   code_o,
  output logic [2*NL-1:0] evt_o,
  output logic            irq_o
);
  localparam int FW = 2 * NL;

  logic          accept;
  logic [CW-1:0] code_q;
  logic [FW-1:0] evt_q, evt_d, evt_set, evt_keep;
  logic          irq_q, irq_d;

  always_comb begin
    accept   = vld_i && run_i && !pd_i;
    evt_set  = accept ? {below_i, above_i} : '0;
    evt_keep = evt_wr_i ? (evt_q & evt_wdata_i) : evt_q;
    evt_d    = evt_keep | evt_set;
    irq_d    = |(evt_q & ena_i & mask_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      evt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (accept) code_q <= code_i;
      if (accept || evt_wr_i) evt_q <= evt_d;
      irq_q <= irq_d;
    end
  end

  assign code_o = code_q;
  assign evt_o  = evt_q;
  assign irq_o  = irq_q;

  // R3: the code register holds while no sample is accepted
  a_r3_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(vld_i && run_i && !pd_i) |=> $stable(code_q));

  // R3: an accepted sample is captured on the next edge
  a_r3_code_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && run_i && !pd_i) |=> (code_q == $past(code_i)));

  // R6: without a status write, no flag ever drops
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_wr_i |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R7: a qualified pending flag raises the interrupt one cycle later
  a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_q & ena_i & mask_i)) |=> irq_q);

  // R7: no pending flag means no interrupt on the following cycle
  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q == '0) |=> !irq_q);
endmodule

// File: rtl/thermal_alert_ctrl.sv
module thermal_alert_ctrl
  import thr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              sample_vld_i,
  input  logic [CODE_W-1:0] sample_code_i,
  output logic              irq_o
);
  localparam int FW = 2 * NUM_LIM;

  logic [1:0] rst_sync;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  logic [NUM_LIM-1:0][CODE_W-1:0] lim;
  logic [FW-1:0]                  ena, mask, evt, evt_wdata;
  logic                           pd, run, evt_wr;
  logic [NUM_LIM-1:0]             above, below;
  logic [CODE_W-1:0]              code;

  thr_regfile u_regs (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .wr_i        (bus_wr_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .rdata_o     (bus_rdata_o),
    .evt_i       (evt),
    .code_i      (code),
    .lim_o       (lim),
    .ena_o       (ena),
    .mask_o      (mask),
    .pd_o        (pd),
    .run_o       (run),
    .evt_wr_o    (evt_wr),
    .evt_wdata_o (evt_wdata)
  );

  thr_compare u_cmp (
    .code_i  (sample_code_i),
    .lim_i   (lim),
    .above_o (above),
    .below_o (below)
  );

  thr_event u_evt (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .pd_i        (pd),
    .run_i       (run),
    .vld_i       (sample_vld_i),
    .code_i      (sample_code_i),
    .above_i     (above),
    .below_i     (below),
    .evt_wr_i    (evt_wr),
    .evt_wdata_i (evt_wdata),
    .ena_i       (ena),
    .mask_i      (mask),
    .code_o      (code),
    .evt_o       (evt),
    .irq_o       (irq_o)
  );
endmodule

// File: tb/thermal_alert_ctrl_test.sv
`timescale 1ns/1ps
module thermal_alert_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        sample_vld;
  logic [11:0] sample_code;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  thermal_alert_ctrl uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr_i      (bus_wr),
    .bus_addr_i    (bus_addr),
    .bus_wdata_i   (bus_wdata),
    .bus_rdata_o   (bus_rdata),
    .sample_vld_i  (sample_vld),
    .sample_code_i (sample_code),
    .irq_o         (irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic sample(logic [11:0] c);
    @(negedge clk);
    sample_vld = 1'b1; sample_code = c;
    @(negedge clk);
    sample_vld = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_check("R1 events", 8'h04, 32'h0);
    rd_check("R1 mask", 8'h08, 32'h0);
    rd_check("R1 icfg", 8'h0C, 32'h0);
    rd_check("R1 enable", 8'h10, 32'h0);
    rd_check("R1 limit1", 8'h14, 32'h0);
    rd_check("R1 limit3", 8'h1C, 32'h0);
    rd_check("R1 ctrl", 8'h20, 32'h40);
    rd_check("R1 code", 8'h28, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regs;
    wr(8'h08, 32'hFFFF_FFFF); rd_check("R2 mask width", 8'h08, 32'h3F);
    wr(8'h10, 32'hFFFF_FFC5); rd_check("R2 enable width", 8'h10, 32'h05);
    wr(8'h0C, 32'hFFFF_FFFF); rd_check("R2 icfg width", 8'h0C, 32'h3F);
    wr(8'h18, 32'hFFFF_FABC); rd_check("R2 limit2 width", 8'h18, 32'hABC);
    wr(8'h20, 32'hFFFF_FFFF); rd_check("R2 ctrl width", 8'h20, 32'h41);
    wr(8'h20, 32'h40);
    wr(8'h08, 32'h0); wr(8'h10, 32'h0); wr(8'h18, 32'h0);
  endtask

  task automatic t_gating;
    sample(12'h123);
    rd_check("R3 pd set start clear", 8'h28, 32'h0);
    wr(8'h20, 32'h41); sample(12'h124);
    rd_check("R3 pd set start set", 8'h28, 32'h0);
    wr(8'h20, 32'h00); sample(12'h125);
    rd_check("R3 start clear", 8'h28, 32'h0);
    rd_check("R3 no flags while stopped", 8'h04, 32'h0);
    wr(8'h20, 32'h01); sample(12'h126);
    rd_check("R3 running accept", 8'h28, 32'h126);
  endtask

  task automatic t_thresholds;
    wr(8'h14, 32'h100); wr(8'h18, 32'h200); wr(8'h1C, 32'h300);
    wr(8'h04, 32'h0);
    sample(12'h200);
    rd_check("R4 R5 equal to limit2", 8'h04, 32'h23);
    wr(8'h04, 32'h0);
    sample(12'h0FF);
    rd_check("R5 below all", 8'h04, 32'h38);
    sample(12'hFFF);
    rd_check("R4 R6 above all sticky", 8'h04, 32'h3F);
    rd_check("R3 code follows", 8'h28, 32'hFFF);
  endtask

  task automatic t_clear;
    wr(8'h04, 32'h07);
    rd_check("R6 partial clear", 8'h04, 32'h07);
    wr(8'h04, 32'h0);
    rd_check("R6 clear all", 8'h04, 32'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0;
    sample_vld = 1'b1; sample_code = 12'h050;
    @(negedge clk);
    bus_wr = 1'b0; sample_vld = 1'b0;
    rd_check("R6 set beats clear", 8'h04, 32'h38);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_irq;
    wr(8'h10, 32'h02); wr(8'h08, 32'h00);
    sample(12'h250);
    idle(2);
    check("R7 masked flag", {31'b0, irq}, 32'h0);
    wr(8'h08, 32'h02);
    check("R7 one cycle latency", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R7 enabled and unmasked", {31'b0, irq}, 32'h1);
    wr(8'h10, 32'h04); wr(8'h08, 32'h04);
    idle(1);
    check("R7 gate on idle flag", {31'b0, irq}, 32'h0);
    wr(8'h10, 32'h20); wr(8'h08, 32'h00);
    idle(1);
    check("R7 enable without mask", {31'b0, irq}, 32'h0);
    wr(8'h10, 32'h01); wr(8'h08, 32'h01);
    idle(1);
    check("R7 bit0 pending", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h0);
    @(negedge clk);
    check("R7 drops after clear", {31'b0, irq}, 32'h0);
    sample(12'h150);
    check("R7 sample latency", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R7 sample raises", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h0); wr(8'h10, 32'h0); wr(8'h08, 32'h0);
  endtask

  task automatic t_reserved;
    wr(8'h08, 32'h15); wr(8'h10, 32'h2A);
    sample(12'h777);
    wr(8'h04, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h28, 32'h0000_0123);
    rd_check("R8 code read only", 8'h28, 32'h777);
    rd_check("R8 mask kept", 8'h08, 32'h15);
    rd_check("R8 enable kept", 8'h10, 32'h2A);
    rd_check("R8 limit1 kept", 8'h14, 32'h100);
    rd_check("R8 ctrl kept", 8'h20, 32'h01);
    rd_check("R8 events kept", 8'h04, 32'h0);
    rd_check("R8 unmapped read", 8'h24, 32'h0);
    rd_check("R8 offset zero read", 8'h00, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    sample_vld = 1'b0; sample_code = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset;
    t_regs;
    t_gating;
    t_thresholds;
    t_clear;
    t_irq;
    t_reserved;
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule